// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block generates the start-up and refresh traffic for an asynchronous 1M x 16 DRAM with split byte column strobes. After reset it holds the row strobe inactive for a programmable power-up pause. It then runs a fixed number of warm-up cycles, each containing a row-strobe pulse. After that it schedules one refresh per interval. The default interval of 1560 cycles at 100 MHz is 15.6 us, which gives 1,024 refreshes in 16 ms.

Each refresh uses one of two styles, chosen per cycle by a mode input. In the column-first style, both column strobes fall before the row strobe, and the DRAM's internal row counter picks the row. In the row-only style, the sequencer places the row from its own 10-bit counter on the address lines and pulses only the row strobe. The DRAM pins are shared with the access controller, so every cycle is requested through a request/grant handshake. Refreshes that cannot be served are counted in a small backlog. A busy flag tells the host side to hold off new accesses while the backlog is full or while start-up is still in progress.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and on leaving reset, `rasN`, `casLoN`, `casHiN`, `weN` and `oeN` are 1, `busReq` is 0, `initDone` is 0 and `busy` is 1.
- R2: For the first PAUSE_CYC clock cycles after reset, `rasN` stays 1 and `busReq` stays 0. A request follows within three cycles after that.
- R3: `initDone` rises at the end of the INIT_CYCLES-th row-strobe cycle after the pause, not earlier. It stays 1 until the next reset.
- R4: After `initDone`, one refresh is scheduled every REFRESH_INT cycles.
- R5: When `cbrMode` is 1 at grant, the cycle is column-first. Both column strobes are low for at least CAS_LEAD cycles before `rasN` falls, and they stay low while `rasN` is low.
- R6: `weN` and `oeN` are 1 at all times. The block drives no data.
- R7: When `cbrMode` is 0 at grant, the cycle is row-only. `addr` carries the internal row number while `rasN` is low, and both column strobes stay 1. The row number rises by one after each row-only cycle and wraps from 1023 to 0. Column-first cycles leave it unchanged.
- R8: `rasN` stays low for at least RAS_ACT cycles in every cycle. It stays high for at least RAS_PRE cycles between two falls.
- R9: `rasN` falls only while `busGrant` is 1. `busReq` stays 1 from the request until the end of precharge.
- R10: Pending refreshes saturate at BACKLOG_MAX. `busy` is 1 while the backlog is full or `initDone` is 0. A granted bus drains the backlog with back-to-back cycles.
- R11: `cbrMode` is sampled once, in the cycle the grant is seen. A later change does not alter a cycle already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cbrMode | input | 1 | 1 selects column-first refresh, 0 selects row-only |
| busGrant | input | 1 | Pin ownership granted by the access controller |
| busReq | output | 1 | Request for the shared DRAM pins |
| pinEn | output | 1 | Sequencer is driving the shared strobe and address pins |
| rasN | output | 1 | Row strobe, active low |
| casLoN | output | 1 | Low-byte column strobe, active low |
| casHiN | output | 1 | High-byte column strobe, active low |
| weN | output | 1 | Write enable, active low (held inactive) |
| oeN | output | 1 | Output enable, active low (held inactive) |
| addr | output | ROW_W | Row address during row-only cycles, otherwise 0 |
| initDone | output | 1 | Start-up sequence complete |
| busy | output | 1 | Host accesses must wait |

## Verification
The bench builds the block with a 50-cycle pause, an interval of 40 cycles, a RAS active time of 4, a precharge of 3, a column lead of 2 and a backlog limit of 3. The eight warm-up cycles are kept. With these values, the pause and start-up sequence finish within about 150 cycles. Enough refreshes fit into a short run that the 10-bit row counter makes a full lap and wraps. A backlog of three is also short enough to reach saturation by withholding the grant, and then drain it with back-to-back cycles.

// File: rtl/drfs_pkg.sv
package drfs_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_REQ,
    S_CASLEAD,
    S_RASACT,
    S_PRE
  } seq_state_t;

  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic rowDrive;
    logic rowStep;
    logic pinEn;
  } strobe_t;

endpackage

// File: rtl/drfs_ctrl.sv
module drfs_ctrl
  import drfs_pkg::*;
#(
  parameter int PAUSE_CYC   = 20000,
  parameter int INIT_CYCLES = 8,
  parameter int REFRESH_INT = 1560,
  parameter int RAS_ACT     = 6,
  parameter int RAS_PRE     = 5,
  parameter int CAS_LEAD    = 2,
  parameter int BACKLOG_MAX = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cbrMode,
  input  logic    busGrant,
  output logic    busReq,
  output logic    initDone,
  output logic    busy,
  output strobe_t strb
);

  localparam int PHASE_MAX = (RAS_ACT > RAS_PRE)
                           ? ((RAS_ACT > CAS_LEAD) ? RAS_ACT : CAS_LEAD)
                           : ((RAS_PRE > CAS_LEAD) ? RAS_PRE : CAS_LEAD);
  localparam int TMR_MAX   = (PAUSE_CYC > PHASE_MAX) ? PAUSE_CYC : PHASE_MAX;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int INIT_W    = $clog2(INIT_CYCLES + 1);
  localparam int TICK_W    = $clog2(REFRESH_INT + 1);
  localparam int PEND_W    = $clog2(BACKLOG_MAX + 1);

  seq_state_t        state;
  logic [TMR_W-1:0]  tmr;
  logic [INIT_W-1:0] initCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [PEND_W-1:0] pending;
  logic              cbrLatched;
  logic              cycleDone;
  logic              refDone;
  logic              tick;
  logic              work;

  assign cycleDone = (state == S_PRE) && (tmr == '0);
  assign refDone   = cycleDone && initDone;
  assign tick      = initDone && (tickCnt == TICK_W'(REFRESH_INT - 1));
  assign work      = !initDone || (pending != '0);

  // sequence state machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_PAUSE;
      tmr        <= TMR_W'(PAUSE_CYC - 1);
      cbrLatched <= 1'b0;
    end else begin
      case (state)
        S_PAUSE: begin
          if (tmr == '0) state <= S_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        S_IDLE: begin
          if (work) state <= S_REQ;
        end
        S_REQ: begin
          if (busGrant) begin
            cbrLatched <= cbrMode;
            if (cbrMode) begin
              state <= S_CASLEAD;
              tmr   <= TMR_W'(CAS_LEAD - 1);
            end else begin
              state <= S_RASACT;
              tmr   <= TMR_W'(RAS_ACT - 1);
            end
          end
        end
        S_CASLEAD: begin
          if (tmr == '0) begin
            state <= S_RASACT;
            tmr   <= TMR_W'(RAS_ACT - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_RASACT: begin
          if (tmr == '0) begin
            state <= S_PRE;
            tmr   <= TMR_W'(RAS_PRE - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_PRE: begin
          if (tmr == '0) state <= S_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // start-up cycle count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else if (cycleDone && !initDone) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == INIT_W'(INIT_CYCLES - 1)) initDone <= 1'b1;
    end
  end

  // refresh interval timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (initDone) begin
      if (tick) tickCnt <= '0;
      else      tickCnt <= tickCnt + 1'b1;
    end
  end

  // backlog of owed refreshes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      case ({tick && (pending != PEND_W'(BACKLOG_MAX)), refDone})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  assign busReq = (state == S_REQ) || (state == S_CASLEAD) ||
                  (state == S_RASACT) || (state == S_PRE);
  assign busy   = !initDone || (pending == PEND_W'(BACKLOG_MAX));

  always_comb begin
    strb          = '0;
    strb.rasLow   = (state == S_RASACT);
    strb.casLow   = cbrLatched && ((state == S_CASLEAD) || (state == S_RASACT));
    strb.rowDrive = !cbrLatched && (state == S_RASACT);
    strb.rowStep  = !cbrLatched && (state == S_RASACT) && (tmr == '0);
    strb.pinEn    = (state == S_CASLEAD) || (state == S_RASACT) || (state == S_PRE);
  end

  // R10
  backlog_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending <= PEND_W'(BACKLOG_MAX));

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !cycleDone) |=> busReq);

endmodule

// File: rtl/drfs_datapath.sv
module drfs_datapath
  import drfs_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic             rasN,
  output logic             casLoN,
  output logic             casHiN,
  output logic             weN,
  output logic             oeN,
  output logic             pinEn,
  output logic [ROW_W-1:0] addr
);

  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN   <= 1'b1;
      casLoN <= 1'b1;
      casHiN <= 1'b1;
      pinEn  <= 1'b0;
      addr   <= '0;
      rowCnt <= '0;
    end else begin
      rasN   <= !strb.rasLow;
      casLoN <= !strb.casLow;
      casHiN <= !strb.casLow;
      pinEn  <= strb.pinEn;
      addr   <= strb.rowDrive ? rowCnt : '0;
      if (strb.rowStep) rowCnt <= rowCnt + 1'b1;
    end
  end

  assign weN = 1'b1;
  assign oeN = 1'b1;

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowCnt != $past(rowCnt)) |-> (rowCnt == $past(rowCnt) + 1'b1));

  // R5
  cas_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casLoN) |-> $past(!casLoN && !casHiN));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drfs_pkg::*;
#(
  parameter int PAUSE_CYC   = 20000,
  parameter int INIT_CYCLES = 8,
  parameter int REFRESH_INT = 1560,
  parameter int RAS_ACT     = 6,
  parameter int RAS_PRE     = 5,
  parameter int CAS_LEAD    = 2,
  parameter int BACKLOG_MAX = 4,
  parameter int ROW_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cbrMode,
  input  logic             busGrant,
  output logic             busReq,
  output logic             pinEn,
  output logic             rasN,
  output logic             casLoN,
  output logic             casHiN,
  output logic             weN,
  output logic             oeN,
  output logic [ROW_W-1:0] addr,
  output logic             initDone,
  output logic             busy
);

  strobe_t strb;

  drfs_ctrl #(
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_CYCLES(INIT_CYCLES),
    .REFRESH_INT(REFRESH_INT),
    .RAS_ACT    (RAS_ACT),
    .RAS_PRE    (RAS_PRE),
    .CAS_LEAD   (CAS_LEAD),
    .BACKLOG_MAX(BACKLOG_MAX)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cbrMode (cbrMode),
    .busGrant(busGrant),
    .busReq  (busReq),
    .initDone(initDone),
    .busy    (busy),
    .strb    (strb)
  );

  drfs_datapath #(
    .ROW_W(ROW_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rasN  (rasN),
    .casLoN(casLoN),
    .casHiN(casHiN),
    .weN   (weN),
    .oeN   (oeN),
    .pinEn (pinEn),
    .addr  (addr)
  );

  // R9
  grant_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> busGrant);

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

  localparam int P_PAUSE = 50;
  localparam int P_INIT  = 8;
  localparam int P_INT   = 40;
  localparam int P_RAS   = 4;
  localparam int P_PRE   = 3;
  localparam int P_LEAD  = 2;
  localparam int P_MAX   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cbrMode = 1'b0;
  logic       arbOn = 1'b0;
  logic       busGrant;
  logic       busReq, pinEn, rasN, casLoN, casHiN, weN, oeN, initDone, busy;
  logic [9:0] addr;

  int total = 0;
  int bad = 0;
  int rasFalls = 0;
  int cbrFalls = 0;
  int lowRun = 0;
  int highRun = 0;
  int casRun = 0;
  int expRow = 0;
  int lastRow = -1;
  bit sawWrap = 0;
  bit curCbr = 0;
  bit prevRas = 1;
  bit prevInit = 0;

  assign busGrant = busReq && arbOn;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .REFRESH_INT(P_INT),
    .RAS_ACT(P_RAS), .RAS_PRE(P_PRE), .CAS_LEAD(P_LEAD),
    .BACKLOG_MAX(P_MAX), .ROW_W(10)
  ) dut (
    .clk(clk), .rstN(rstN), .cbrMode(cbrMode), .busGrant(busGrant),
    .busReq(busReq), .pinEn(pinEn), .rasN(rasN), .casLoN(casLoN),
    .casHiN(casHiN), .weN(weN), .oeN(oeN), .addr(addr),
    .initDone(initDone), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // pin monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (!weN || !oeN) check(0, "R6 we/oe inactive", {weN, oeN}, 3);
      if (prevInit && !initDone) check(0, "R3 initDone sticky", 0, 1);
      if (!rasN && prevRas) begin
        rasFalls++;
        check(busGrant, "R9 grant at ras fall", busGrant, 1);
        if (rasFalls > 1) check(highRun >= P_PRE, "R8 precharge", highRun, P_PRE);
        if (!casLoN) begin
          curCbr = 1;
          cbrFalls++;
          check(casRun >= P_LEAD && !casHiN, "R5 cas lead", casRun, P_LEAD);
        end else begin
          curCbr = 0;
          check(casHiN && addr == expRow[9:0], "R7 row address", addr, expRow);
          if (lastRow == 1023 && addr == 10'd0) sawWrap = 1;
          lastRow = addr;
          expRow = (expRow + 1) % 1024;
        end
        lowRun = 1;
      end else if (!rasN) begin
        lowRun++;
        if (!busGrant) check(0, "R9 grant during ras", 0, 1);
        if (curCbr && (casLoN || casHiN)) check(0, "R5 cas held low", casLoN, 0);
        if (!curCbr && (!casLoN || !casHiN)) check(0, "R7 cas stays high", casLoN, 1);
      end
      if (rasN && !prevRas) begin
        check(lowRun >= P_RAS, "R8 ras active", lowRun, P_RAS);
        highRun = 1;
      end else if (rasN) begin
        highRun++;
      end
      casRun = casLoN ? 0 : casRun + 1;
      prevRas = rasN;
      prevInit = initDone;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setArb(input bit on);
    @(negedge clk);
    while (busReq) @(negedge clk);
    arbOn = on;
  endtask

  task automatic test_reset;
    @(negedge clk);
    check(rasN && casLoN && casHiN && weN && oeN, "R1 strobes idle", {rasN, casLoN, casHiN}, 7);
    check(!busReq && !initDone && busy, "R1 flags", {busReq, initDone, busy}, 1);
  endtask

  task automatic test_pause;
    bit ok = 1;
    bit seen = 0;
    arbOn = 1;
    rstN = 1;
    for (int i = 0; i < P_PAUSE; i++) begin
      @(negedge clk);
      if (!rasN || busReq) ok = 0;
    end
    check(ok, "R2 quiet pause", ok, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (busReq) seen = 1;
    end
    check(seen, "R2 request after pause", seen, 1);
  endtask

  task automatic test_init;
    int guard = 0;
    while (!initDone && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(initDone, "R3 initDone reached", initDone, 1);
    check(rasFalls == P_INIT, "R3 start-up cycle count", rasFalls, P_INIT);
    waitCycles(2);
    check(!busy, "R10 busy clears after start-up", busy, 0);
  endtask

  task automatic test_rate;
    int f0 = rasFalls;
    waitCycles(20 * P_INT);
    check(rasFalls - f0 >= 19 && rasFalls - f0 <= 21, "R4 refresh rate", rasFalls - f0, 20);
  endtask

  task automatic test_cbr;
    int c0 = cbrFalls;
    cbrMode = 1;
    waitCycles(10 * P_INT);
    cbrMode = 0;
    check(cbrFalls - c0 >= 9, "R5 column-first cycles issued", cbrFalls - c0, 10);
    waitCycles(3 * P_INT);
    check(lastRow == (expRow + 1023) % 1024, "R7 row kept across column-first", lastRow, (expRow + 1023) % 1024);
  endtask

  task automatic test_backlog;
    int f0;
    int quiet = 0;
    int guard = 0;
    setArb(0);
    waitCycles((P_MAX + 2) * P_INT);
    check(busy && busReq, "R10 busy when backlog full", {busy, busReq}, 3);
    f0 = rasFalls;
    arbOn = 1;
    while (quiet < 3 && guard < 500) begin
      @(negedge clk);
      guard++;
      quiet = busReq ? 0 : quiet + 1;
    end
    check(rasFalls - f0 >= P_MAX && rasFalls - f0 <= P_MAX + 1, "R10 backlog saturation", rasFalls - f0, P_MAX);
    check(!busy, "R10 busy after drain", busy, 0);
  endtask

  task automatic test_modelatch;
    int c0 = cbrFalls;
    int guard = 0;
    setArb(0);
    while (!busReq && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    cbrMode = 1;
    arbOn = 1;
    @(negedge clk);
    cbrMode = 0;
    waitCycles(P_LEAD + P_RAS + 2);
    check(cbrFalls - c0 == 1, "R11 mode taken at grant", cbrFalls - c0, 1);
  endtask

  task automatic test_wrap;
    int guard = 0;
    while (!sawWrap && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    check(sawWrap, "R7 row wrap", sawWrap, 1);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitCycles(3);
    test_reset();
    test_pause();
    test_init();
    test_rate();
    test_cbr();
    test_backlog();
    test_modelatch();
    test_wrap();
    waitCycles(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule